// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

A purely combinational N-bit arithmetic logic unit assembled from N identical one-bit slices. Each slice holds four pieces. The first is a conditioning mux that turns the operand bit B into an adder input Y. The second is a full adder that sums A, Y and the incoming carry. The third is a four-way logic mux. The fourth is a 2:1 output mux that returns either the arithmetic bit or the logic bit. The carry ripples from slice 0 up to slice N-1. The last carry leaves the unit as the carry-out.

All arithmetic operations come from one adder equation, G = A + Y + carry-in. The two low select bits choose what Y is: all zeros, B, the complement of B, or all ones. The carry-in then adds one or nothing. This gives transfer, increment, add, add with carry, subtract and decrement without any extra logic. The top select bit switches every slice over to the logic result. The same select and carry-in lines drive every slice.

Top module: `bsalu`

## Requirements
- R1: With sel_i[2]=0, {cout_o, g_o} equals the (N+1)-bit sum A + Y + cin_i. sel_i[1] is S1 and sel_i[0] is S0. Y is chosen by {S1,S0}: 00 gives zero, 01 gives B, 10 gives ~B, 11 gives all ones.
- R2: sel_i=000 with cin_i=0 passes A to g_o, and cout_o=0.
- R3: sel_i=000 with cin_i=1 returns A+1 mod 2^N. cout_o=1 only when A is all ones.
- R4: sel_i=001 returns A+B when cin_i=0 and A+B+1 when cin_i=1. cout_o is the carry out of bit N-1.
- R5: sel_i=010 with cin_i=0 returns A + ~B, which equals A-B-1 mod 2^N.
- R6: sel_i=010 with cin_i=1 returns A-B mod 2^N. cout_o=1 exactly when A >= B as unsigned numbers.
- R7: sel_i=011 with cin_i=0 returns A-1 mod 2^N. cout_o=1 exactly when A is not zero.
- R8: sel_i=011 with cin_i=1 passes A to g_o, and cout_o=1.
- R9: With sel_i[2]=1, g_o depends on sel_i[1:0]: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, 11 gives NOT A.
- R10: With sel_i[2]=1, cin_i has no effect on g_o.
- R11: The carry ripples through every slice. For example, A=all ones, B=0, sel_i=000, cin_i=1 gives g_o=0 and cout_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Operand A |
| b_i | input | N | Operand B |
| sel_i | input | 3 | Operation select: bit 2 picks logic, bits 1:0 condition B or pick the logic function |
| cin_i | input | 1 | Carry into slice 0 |
| g_o | output | N | Result |
| cout_o | output | 1 | Carry out of slice N-1 |

## Verification
The checker re-derives the adder sum from the Y encoding and the logic function for every input combination. It also holds the subtract, decrement, transfer and wrap-around cases to their closed forms whenever those codes appear. The properties cannot show two things, and only the bench scenarios can. One is that cin_i is really ignored when the logic path is selected, which needs a pair of vectors that differ only in the carry. The other is that a carry actually travels the full width, which needs chosen operands such as all ones plus one.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    LOG_AND = 2'b00,
    LOG_OR  = 2'b01,
    LOG_XOR = 2'b10,
    LOG_NOT = 2'b11
  } logic_op_e;
endpackage

// File: rtl/bsalu_cond.sv
// B conditioning: the data bit steers a 2:1 mux between the select lines.
module bsalu_cond (
  input  logic b_i,
  input  logic s1_i,
  input  logic s0_i,
  output logic y_o
);
  always_comb y_o = b_i ? s0_i : s1_i;
endmodule

// File: rtl/bsalu_fa.sv
module bsalu_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  always_comb begin
    p   = a_i ^ b_i;
    s_o = p ^ c_i;
    c_o = (a_i & b_i) | (p & c_i);
  end
endmodule

// File: rtl/bsalu_logic.sv
module bsalu_logic
  import bsalu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic [1:0] op_i,
  output logic      g_o
);
  always_comb begin
    unique case (logic_op_e'(op_i))
      LOG_AND: g_o = a_i & b_i;
      LOG_OR:  g_o = a_i | b_i;
      LOG_XOR: g_o = a_i ^ b_i;
      LOG_NOT: g_o = ~a_i;
      default: g_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic             a_i,
  input  logic             b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             c_i,
  output logic             g_o,
  output logic             c_o
);
  logic y, arith, lgc;

  bsalu_cond u_cond (
    .b_i (b_i),
    .s1_i(sel_i[1]),
    .s0_i(sel_i[0]),
    .y_o (y)
  );

  bsalu_fa u_fa (
    .a_i(a_i),
    .b_i(y),
    .c_i(c_i),
    .s_o(arith),
    .c_o(c_o)
  );

  bsalu_logic u_logic (
    .a_i (a_i),
    .b_i (b_i),
    .op_i(sel_i[1:0]),
    .g_o (lgc)
  );

  always_comb g_o = sel_i[2] ? lgc : arith;
endmodule

// File: rtl/bsalu.sv
module bsalu
  import bsalu_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]     a_i,
  input  logic [N-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cin_i,
  output logic [N-1:0]     g_o,
  output logic             cout_o
);
  localparam int unsigned CW = N + 1;

  logic [CW-1:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < N; i++) begin : g_slice
    bsalu_slice u_slice (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .sel_i(sel_i),
      .c_i  (carry[i]),
      .g_o  (g_o[i]),
      .c_o  (carry[i+1])
    );
  end

  assign cout_o = carry[N];
endmodule

// File: rtl/bsalu_chk.sv
module bsalu_chk
  import bsalu_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input logic [N-1:0]     a_i,
  input logic [N-1:0]     b_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             cin_i,
  input logic [N-1:0]     g_o,
  input logic             cout_o
);
  logic [N:0]   ref_sum;
  logic [N-1:0] y_ref;
  logic [N-1:0] lg_ref;

  always_comb begin
    case (sel_i[1:0])
      2'b00:   y_ref = '0;
      2'b01:   y_ref = b_i;
      2'b10:   y_ref = ~b_i;
      default: y_ref = '1;
    endcase
    ref_sum = {1'b0, a_i} + {1'b0, y_ref} + {{N{1'b0}}, cin_i};
    case (sel_i[1:0])
      2'b00:   lg_ref = a_i & b_i;
      2'b01:   lg_ref = a_i | b_i;
      2'b10:   lg_ref = a_i ^ b_i;
      default: lg_ref = ~a_i;
    endcase
  end

  always_comb begin
    if (!sel_i[2])
      AST_ARITH_SUM: assert ({cout_o, g_o} == ref_sum); // R1
    if (sel_i[2])
      AST_LOGIC_OP: assert (g_o == lg_ref); // R9
    if (sel_i == 3'b000 && !cin_i)
      AST_XFER_PLAIN: assert (g_o == a_i && !cout_o); // R2
    if (sel_i == 3'b010 && cin_i)
      AST_SUB_BORROW: assert (g_o == a_i - b_i && cout_o == (a_i >= b_i)); // R6
    if (sel_i == 3'b011 && !cin_i)
      AST_DEC_CARRY: assert (g_o == a_i - 1'b1 && cout_o == (a_i != '0)); // R7
    if (sel_i == 3'b011 && cin_i)
      AST_XFER_WRAP: assert (g_o == a_i && cout_o); // R8
  end
endmodule

bind bsalu bsalu_chk #(.N(N)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sel_i (sel_i),
  .cin_i (cin_i),
  .g_o   (g_o),
  .cout_o(cout_o)
);

// File: tb/bsalu_test.sv
module bsalu_test;
  localparam int unsigned N = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WDOG_LIMIT = 100000;
  localparam int unsigned N_RAND = 3000;

  typedef struct {
    logic [N-1:0] g;
    logic         co;
    logic         care_co;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] a, b;
  logic [2:0]   sel;
  logic         cin;
  logic [N-1:0] g;
  logic         cout;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsalu #(.N(N)) uut (
    .a_i   (a),
    .b_i   (b),
    .sel_i (sel),
    .cin_i (cin),
    .g_o   (g),
    .cout_o(cout)
  );

  function automatic item_t model(logic [N-1:0] fa, logic [N-1:0] fb,
                                  logic [2:0] fs, logic fc, string tag);
    item_t it;
    logic [N:0] ea, eb, nb, ones, r;
    ea = {1'b0, fa};
    eb = {1'b0, fb};
    nb = {1'b0, ~fb};
    ones = {1'b0, {N{1'b1}}};
    it.tag = tag;
    if (!fs[2]) begin
      case ({fs[1:0], fc})
        3'b000: r = ea;
        3'b001: r = ea + 1;
        3'b010: r = ea + eb;
        3'b011: r = ea + eb + 1;
        3'b100: r = ea + nb;
        3'b101: r = ea + nb + 1;
        3'b110: r = ea + ones;
        default: r = ea + ones + 1;
      endcase
      it.g = r[N-1:0];
      it.co = r[N];
      it.care_co = 1'b1;
    end else begin
      case (fs[1:0])
        2'b00: it.g = fa & fb;
        2'b01: it.g = fa | fb;
        2'b10: it.g = fa ^ fb;
        default: it.g = ~fa;
      endcase
      it.co = 1'b0;
      it.care_co = 1'b0;
    end
    return it;
  endfunction

  function automatic string tag_of(logic [2:0] fs, logic fc);
    if (fs[2]) return "R9";
    case ({fs[1:0], fc})
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010, 3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      3'b110: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(logic [N-1:0] ta, logic [N-1:0] tb, logic [2:0] ts,
                       logic tc, string tag);
    @(posedge clk);
    a = ta; b = tb; sel = ts; cin = tc;
    sb_q.push_back(model(ta, tb, ts, tc, tag));
  endtask

  // monitor: combinational result is settled by the falling edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (g !== it.g || (it.care_co && cout !== it.co)) begin
        errors++;
        $display("FAIL %s: g=%h cout=%b expected g=%h cout=%b (a=%h b=%h sel=%b cin=%b)",
                 it.tag, g, cout, it.g, it.co, a, b, sel, cin);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WDOG_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sel = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands transfer to zero
    drive('0, '0, 3'b000, 1'b0, "R2");
    drive(8'h3C, 8'hC3, 3'b000, 1'b0, "R2");
    drive(8'h10, 8'h20, 3'b001, 1'b0, "R1");
    drive(8'h10, 8'h20, 3'b000, 1'b1, "R1");
    drive(8'hFF, 8'h00, 3'b000, 1'b1, "R3");
    drive(8'h7F, 8'h01, 3'b001, 1'b0, "R4");
    drive(8'hF0, 8'h20, 3'b001, 1'b1, "R4");
    drive(8'h05, 8'h03, 3'b010, 1'b0, "R5");
    drive(8'h03, 8'h05, 3'b010, 1'b1, "R6");
    drive(8'h05, 8'h05, 3'b010, 1'b1, "R6");
    drive(8'h00, 8'h77, 3'b011, 1'b0, "R7");
    drive(8'h80, 8'h77, 3'b011, 1'b0, "R7");
    drive(8'h5A, 8'h00, 3'b011, 1'b1, "R8");
    drive(8'hCA, 8'h5C, 3'b100, 1'b0, "R9");
    drive(8'hCA, 8'h5C, 3'b101, 1'b0, "R9");
    drive(8'hCA, 8'h5C, 3'b110, 1'b0, "R9");
    drive(8'hCA, 8'h5C, 3'b111, 1'b0, "R9");
    // cin toggled on the logic path must leave g unchanged
    for (int k = 0; k < 4; k++) begin
      drive(8'h96, 8'h3B, {1'b1, 2'(k)}, 1'b0, "R10");
      drive(8'h96, 8'h3B, {1'b1, 2'(k)}, 1'b1, "R10");
    end
    drive(8'hFF, 8'h00, 3'b000, 1'b1, "R11");
    drive(8'hAA, 8'h55, 3'b001, 1'b1, "R11");
    drive(8'h00, 8'h01, 3'b010, 1'b1, "R11");
    for (int n = 0; n < N_RAND; n++) begin
      logic [2:0] rs;
      logic rc;
      rs = 3'($urandom);
      rc = 1'($urandom);
      drive(N'($urandom), N'($urandom), rs, rc, tag_of(rs, rc));
    end
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule